// File: doc/BRIEF.md
# Delayed One-Shot Pulse Generator

This block produces one output pulse per start event. The time from the start event to the pulse edge and the length of the pulse are both programmable. Two identical down-counting channels are chained. The first one, the delay channel, is started by the start event and counts out the delay. Its terminal strobe starts the second one, the width channel. That channel holds the pulse output high while it counts out the width. Both channels advance only on cycles where the count-clock enable `tick` is high. A prescaler elsewhere sets the time base, and every time below is given in ticks.

A start event is either a one-cycle software strobe or a rising edge on an asynchronous trigger pin, which is resynchronized internally. Each channel samples its reload value at the moment it loads. A new value can therefore be written for the next shot once that channel has reported completion. The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal, and each strobe lasts one clock cycle.

Top module: `dly_oneshot`

Time is measured in ticks after the trigger edge. For `sw_start` the trigger edge is the clock edge that samples `sw_start` high. For `trig_in` it is the third rising clock edge that samples `trig_in` high. A tick sampled on the trigger edge itself is not counted. The first `tick` sampled on a later edge is tick 1. D = `delay_rld` and W = `width_rld`, both unsigned 16-bit values.

## Requirements
- R1: While reset is active and after it is released, `pulse_out`, `delay_done` and `width_done` are 0, and no pulse appears until a start event.
- R2: After a `sw_start` trigger edge, `pulse_out` rises on the clock edge that samples tick number D+2.
- R3: `pulse_out` stays high for exactly W ticks and falls on the edge that samples tick D+2+W. `width_done` is high for the one cycle after that edge. When W = 0 there is no pulse, and `width_done` follows tick D+2.
- R4: `delay_done` is high for the single cycle after the edge that samples tick D+1, so with D = 0 it follows tick 1.
- R5: `trig_in` passes through a two-flop synchronizer. Only a 0-to-1 transition starts a shot. Holding the pin high, or letting it fall, starts nothing.
- R6: Counting advances only on edges that sample `tick` high. The three outputs change only on such edges.
- R7: A start event that arrives while the delay channel is counting restarts the delay from D. The new count begins with the next tick.
- R8: `delay_rld` is sampled on tick 1 and `width_rld` on tick D+2. Changing either value after its sampling point has no effect on the shot in progress.
- R9: When a shot is finished, all outputs stay low and the channels stay idle until the next start event, even with `tick` active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-clock enable, one cycle per count period |
| trig_in | input | 1 | Asynchronous trigger pin; a rising edge starts a shot |
| sw_start | input | 1 | Software start strobe, synchronous |
| delay_rld | input | CNT_W | Delay reload value D |
| width_rld | input | CNT_W | Width reload value W |
| pulse_out | output | 1 | One-shot pulse output, active high |
| delay_done | output | 1 | One-cycle strobe when the delay count ends |
| width_done | output | 1 | One-cycle strobe when the width count ends |

## Verification
Shots are started both by the software strobe and by the pin. For the pin, the bench checks the two-edge synchronizer offset, and it holds the pin high afterwards to separate edge detection from level detection. `tick` is driven every cycle and also at random sparse rates. This separates counting in ticks from counting in clock cycles, and it catches a load that happens on the same edge as the trigger. The directed cases cover D = 0 and W = 0, a restart in the middle of the delay, and reload values rewritten after each sampling point. Random D and W values are then checked cycle by cycle against the tick-count formulas.

// File: rtl/dlyp_pkg.sv
package dlyp_pkg;
  localparam int DEF_CNT_W  = 16;
  localparam int DEF_STAGES = 2;

  // per-channel control flags
  typedef struct packed {
    logic run;  // counting down
    logic arm;  // start seen, waiting for the next tick to load
  } chan_flags_t;
endpackage

// File: rtl/dlyp_sync_edge.sv
module dlyp_sync_edge #(
  parameter int STAGES = dlyp_pkg::DEF_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  localparam int TOP = STAGES;

  logic [TOP:0] sh;

  // sh[0..STAGES-1] is the synchronizer chain; sh[TOP] holds the previous level
  generate
    for (genvar i = 0; i <= TOP; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sh[i] <= 1'b0;
          else        sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign rise = sh[TOP-1] & ~sh[TOP];
endmodule

// File: rtl/dlyp_chan.sv
module dlyp_chan
  import dlyp_pkg::*;
#(
  parameter int CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [CNT_W-1:0] rld,
  output logic             running,
  output logic             done
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  chan_flags_t      fl;
  logic [CNT_W-1:0] cnt;
  logic             pending, load, expire;

  assign pending = start | fl.arm;
  assign load    = tick & pending;
  assign expire  = tick & fl.run & (cnt == ONE) & ~pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl   <= '0;
      cnt  <= ZERO;
      done <= 1'b0;
    end else begin
      done <= (load & (rld == ZERO)) | expire;
      if (load) begin
        // reload value is sampled only here
        cnt    <= rld;
        fl.run <= (rld != ZERO);
        fl.arm <= 1'b0;
      end else begin
        if (start) fl.arm <= 1'b1;
        if (tick && fl.run) begin
          if (cnt == ONE) begin
            cnt    <= ZERO;
            fl.run <= 1'b0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
      end
    end
  end

  assign running = fl.run;
endmodule

// File: rtl/dly_oneshot.sv
module dly_oneshot
  import dlyp_pkg::*;
#(
  parameter int CNT_W  = DEF_CNT_W,
  parameter int STAGES = DEF_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             trig_in,
  input  logic             sw_start,
  input  logic [CNT_W-1:0] delay_rld,
  input  logic [CNT_W-1:0] width_rld,
  output logic             pulse_out,
  output logic             delay_done,
  output logic             width_done
);
  logic pin_rise;
  logic trig_q;
  logic m_busy, m_done;
  logic s_busy, s_done;

  dlyp_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (trig_in),
    .rise (pin_rise)
  );

  // registered start event: its cycle plays the same role as a done strobe
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= pin_rise | sw_start;

  dlyp_chan #(.CNT_W(CNT_W)) u_delay (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .start  (trig_q),
    .rld    (delay_rld),
    .running(m_busy),
    .done   (m_done)
  );

  dlyp_chan #(.CNT_W(CNT_W)) u_width (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .start  (m_done),
    .rld    (width_rld),
    .running(s_busy),
    .done   (s_done)
  );

  assign pulse_out  = s_busy;
  assign delay_done = m_done;
  assign width_done = s_done;
endmodule

// File: rtl/dly_oneshot_chk.sv
module dly_oneshot_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic pulse_out,
  input logic delay_done,
  input logic width_done,
  input logic m_busy
);
  a_r6_pulse_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out != $past(pulse_out)) |-> $past(tick));

  a_r4_delay_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    delay_done |-> $past(tick));

  a_r6_width_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    width_done |-> $past(tick));

  a_r3_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_out) |-> width_done);

  a_r3_done_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
    width_done |-> !pulse_out);

  a_r4_done_ends_delay: assert property (@(posedge clk) disable iff (!rst_n)
    delay_done |-> !m_busy);
endmodule

bind dly_oneshot dly_oneshot_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .pulse_out (pulse_out),
  .delay_done(delay_done),
  .width_done(width_done),
  .m_busy    (m_busy)
);

// File: tb/sim_dly_oneshot.sv
module sim_dly_oneshot;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         trig_in = 1'b0;
  logic         sw_start = 1'b0;
  logic [W-1:0] delay_rld = '0;
  logic [W-1:0] width_rld = '0;
  logic         pulse_out, delay_done, width_done;
  int           checks = 0;
  int           failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_oneshot #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in), .sw_start(sw_start),
    .delay_rld(delay_rld), .width_rld(width_rld),
    .pulse_out(pulse_out), .delay_done(delay_done), .width_done(width_done)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  // expected outputs from the tick-count formulas
  function automatic logic exp_pulse(int n, int d, int w);
    return (n >= d + 2) && (n < d + 2 + w);
  endfunction
  function automatic logic exp_ddone(logic tv, int n, int d);
    return tv && (n == d + 1);
  endfunction
  function automatic logic exp_wdone(logic tv, int n, int d, int w);
    return tv && (n == d + 2 + w);
  endfunction

  task automatic idle(input int cycles, input int div);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      sw_start = 1'b0;
      tick = (($urandom % div) == 0);
      @(posedge clk); #1;
      chk("R9 idle pulse", pulse_out, 1'b0);
      chk("R9 idle delay_done", delay_done, 1'b0);
      chk("R9 idle width_done", width_done, 1'b0);
    end
  endtask

  // one shot: ext selects the pin, retrig>0 restarts at that tick, chg rewrites reloads
  task automatic shot(input int d, input int w, input bit ext, input int div,
                      input int retrig, input bit chg);
    int   n = 0;
    int   pre = ext ? 2 : 0;
    bit   started = 0, rt_pend = 0, rt_done = 0, c1 = 0, c2 = 0;
    logic tv;
    delay_rld = W'(d);
    width_rld = W'(w);
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      sw_start = 1'b0;
      if (cyc == 0) begin
        if (ext) trig_in = 1'b1; else sw_start = 1'b1;
      end
      if (started && retrig > 0 && !rt_done && n == retrig) begin
        sw_start = 1'b1; rt_pend = 1; rt_done = 1;   // R7 restart
      end
      if (chg && started && n >= 1 && !c1) begin
        delay_rld = W'(d + 7); c1 = 1;               // R8 after delay sample
      end
      if (chg && started && n >= d + 2 && !c2) begin
        width_rld = W'(w + 5); c2 = 1;               // R8 after width sample
      end
      tv = (($urandom % div) == 0);
      tick = tv;
      @(posedge clk); #1;
      if (!started) begin
        if (pre == 0) started = 1; else pre--;
      end else if (rt_pend) begin
        n = 0; rt_pend = 0;
      end else if (tv) begin
        n++;
      end
      if (!started) begin
        chk("R5 no output before sync", pulse_out, 1'b0);
      end else begin
        chk(ext ? "R5/R2 pulse" : "R2/R3 pulse", pulse_out, exp_pulse(n, d, w));
        chk("R4 delay_done", delay_done, exp_ddone(tv, n, d));
        chk("R3 width_done", width_done, exp_wdone(tv, n, d, w));
      end
      if (started && n >= d + w + 4) break;
    end
    // trig_in stays high above; lowering it must not start anything (R5)
    trig_in = 1'b0;
    sw_start = 1'b0;
    idle(4, div);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pulse", pulse_out, 1'b0);
    chk("R1 reset delay_done", delay_done, 1'b0);
    chk("R1 reset width_done", width_done, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle(5, 1);                     // R1 nothing without a start

    shot(0, 0, 0, 1, 0, 0);         // R4 D=0, R3 W=0
    shot(0, 1, 0, 1, 0, 0);
    shot(1, 1, 0, 2, 0, 0);
    shot(3, 0, 0, 3, 0, 0);         // R3 no pulse
    shot(5, 3, 1, 1, 0, 0);         // R5 pin trigger
    shot(4, 2, 1, 3, 0, 0);         // R5 with sparse ticks
    shot(6, 4, 0, 1, 3, 0);         // R7 restart mid-delay
    shot(5, 2, 0, 2, 2, 0);         // R7 sparse ticks
    shot(4, 3, 0, 1, 0, 1);         // R8 reload rewrite
    shot(2, 6, 0, 3, 0, 1);         // R8 sparse ticks
    idle(10, 1);                    // R9 held idle

    for (int k = 0; k < 40; k++) begin
      int  d   = $urandom % 13;
      int  w   = $urandom % 11;
      bit  ext = $urandom % 2;
      int  div = 1 + ($urandom % 3);  // R6 random tick rate
      shot(d, w, ext, div, 0, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule